// File: doc/BRIEF.md
# Indexed-Configuration Instruction Sequencer

This block steps through a small program store, one instruction word per clock, and drives a wide bus of control words into a datapath. An instruction word does not carry those control words. For each controlled unit it holds a short index into a small per-unit table of configurations. On every cycle the sequencer looks up the selected entry of each table and registers the result onto the control bus, so the datapath can take a new configuration each cycle. A configuration used by many instructions is stored once and named by a few index bits in each of them.

The program flows sequentially, with unconditional jumps and jumps taken on an external flag, both to an absolute address. A stop instruction halts the sequencer and raises `done`. A pulse on `start` restarts the program from address 0. While the sequencer is not running, the program store and every configuration table can be loaded through one address/data/write-enable port.

Control is a three-state machine. IDLE is the state after reset. RUN executes one instruction per cycle. DONE is entered when a stop instruction executes. Its transitions are: IDLE to RUN on `start`; RUN to DONE on a stop opcode; DONE to RUN on `start`. RUN to RUN covers every other opcode.

Top module: `cfg_seq_top`

## Requirements
- R1: After reset `busy`, `done`, `pc` and all of `ctrl_out` are 0, and `busy` and `done` are never high together.
- R2: A `start` seen while idle or done puts the block in RUN with `pc` = 0 on the next cycle. A `start` seen during RUN has no effect on `pc` or the flow.
- R3: An instruction word is 20 bits. Bits [19:18] hold the opcode: 0 = step, 1 = jump, 2 = jump-if-flag, 3 = stop. A step opcode loads `pc` with `pc`+1, and address 63 wraps to 0.
- R4: A jump opcode loads `pc` with the target field, bits [17:12].
- R5: A jump-if-flag opcode loads `pc` with the target when `flag` is 1 in that cycle, and with `pc`+1 otherwise. `flag` is ignored by every other opcode.
- R6: A stop opcode holds `pc`, drops `busy` and raises `done` on the next cycle. `done` and `pc` then hold until `start`.
- R7: Bits [3u+2:3u] of an instruction index the 8-entry table of unit u (u = 0..3). One cycle after an instruction is fetched, `ctrl_out[16u+15:16u]` equals that table entry. The stop instruction's own indices are applied as well.
- R8: `ctrl_out` does not change while the block is not in RUN, including when tables are written.
- R9: With `wr_en` = 1 and `wr_sel` = 0, `wr_data` is stored at program address `wr_addr`. With `wr_sel` = 1, `wr_data[15:0]` is stored in entry `wr_addr[2:0]` of unit `wr_addr[4:3]`. Writes made during RUN are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin execution from address 0 |
| flag | input | 1 | Condition for jump-if-flag |
| wr_en | input | 1 | Write strobe for the load port |
| wr_sel | input | 1 | 0 = program store, 1 = configuration tables |
| wr_addr | input | 6 | Program address, or {unit, entry} for tables |
| wr_data | input | 20 | Instruction word, or control word in bits [15:0] |
| ctrl_out | output | 64 | Four registered 16-bit control words, unit 0 lowest |
| pc | output | 6 | Address of the instruction fetched next |
| busy | output | 1 | High in RUN |
| done | output | 1 | High after a stop instruction until the next start |

## Verification
The flow properties assume that `flag` and `start` are settled before each rising edge. The bench changes them only at falling edges. The properties also assume that the fetched instruction is the one the program store holds. This holds because writes during RUN are dropped, and the bench tries such a write on purpose and then checks the control words that follow. The programs keep each run finite with a reachable stop instruction, and they take jump-if-flag both ways and cross the wrap from address 63 to 0.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [1:0] {
        OP_NEXT = 2'd0,
        OP_JUMP = 2'd1,
        OP_JMPF = 2'd2,
        OP_HALT = 2'd3
    } opcode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } seq_state_e;

    localparam int OP_W = 2;

endpackage

// File: rtl/cfgseq_imem.sv
module cfgseq_imem #(
    parameter int DEPTH  = 64,
    parameter int WIDTH  = 20,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/cfgseq_cfgbank.sv
module cfgseq_cfgbank #(
    parameter int DEPTH  = 8,
    parameter int CTRL_W = 16,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     waddr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              issue,
    input  logic [IW-1:0]     sel,
    output logic [CTRL_W-1:0] word_q
);

    logic [CTRL_W-1:0] table_r [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            table_r[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (issue) begin
            word_q <= table_r[sel];
        end
    end

endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
    import cfgseq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          flag,
    input  logic [OP_W-1:0] op,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc,
    output logic          issue,
    output logic          busy,
    output logic          done
);

    seq_state_e state_q, state_n;
    logic [AW-1:0] pc_q, pc_n;
    opcode_e opv;

    assign opv = opcode_e'(op);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pc_q    <= '0;
        end else begin
            state_q <= state_n;
            pc_q    <= pc_n;
        end
    end

    always_comb begin
        state_n = state_q;
        pc_n    = pc_q;
        case (state_q)
            S_IDLE, S_DONE: begin
                if (start) begin
                    state_n = S_RUN;
                    pc_n    = '0;
                end
            end
            S_RUN: begin
                unique case (opv)
                    OP_NEXT: pc_n = pc_q + 1'b1;
                    OP_JUMP: pc_n = target;
                    OP_JMPF: pc_n = flag ? target : pc_q + 1'b1;
                    OP_HALT: state_n = S_DONE;
                endcase
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_comb begin
        pc    = pc_q;
        issue = (state_q == S_RUN);
        busy  = (state_q == S_RUN);
        done  = (state_q == S_DONE);
    end

endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
    import cfgseq_pkg::*;
#(
    parameter int N_UNITS    = 4,
    parameter int CFG_DEPTH  = 8,
    parameter int CTRL_W     = 16,
    parameter int IMEM_DEPTH = 64,
    localparam int IDX_W   = $clog2(CFG_DEPTH),
    localparam int ADDR_W  = $clog2(IMEM_DEPTH),
    localparam int UNIT_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
    localparam int INSTR_W = OP_W + ADDR_W + N_UNITS * IDX_W,
    localparam int WA_W    = (ADDR_W > UNIT_W + IDX_W) ? ADDR_W : UNIT_W + IDX_W,
    localparam int DATA_W  = (INSTR_W > CTRL_W) ? INSTR_W : CTRL_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      flag,
    input  logic                      wr_en,
    input  logic                      wr_sel,
    input  logic [WA_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [N_UNITS*CTRL_W-1:0] ctrl_out,
    output logic [ADDR_W-1:0]         pc,
    output logic                      busy,
    output logic                      done
);

    logic [INSTR_W-1:0] cur_instr;
    logic [OP_W-1:0]    cur_op;
    logic [ADDR_W-1:0]  cur_target;
    logic               issue;
    logic               load_ok;

    assign cur_op     = cur_instr[INSTR_W-1 -: OP_W];
    assign cur_target = cur_instr[N_UNITS*IDX_W +: ADDR_W];
    assign load_ok    = wr_en && !busy;

    cfgseq_fsm #(.AW(ADDR_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .flag   (flag),
        .op     (cur_op),
        .target (cur_target),
        .pc     (pc),
        .issue  (issue),
        .busy   (busy),
        .done   (done)
    );

    cfgseq_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(INSTR_W)) u_imem (
        .clk   (clk),
        .we    (load_ok && !wr_sel),
        .waddr (wr_addr[ADDR_W-1:0]),
        .wdata (wr_data[INSTR_W-1:0]),
        .raddr (pc),
        .rdata (cur_instr)
    );

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        logic bank_we;
        assign bank_we = load_ok && wr_sel &&
                         (wr_addr[IDX_W +: UNIT_W] == UNIT_W'(u));
        cfgseq_cfgbank #(.DEPTH(CFG_DEPTH), .CTRL_W(CTRL_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (bank_we),
            .waddr  (wr_addr[IDX_W-1:0]),
            .wdata  (wr_data[CTRL_W-1:0]),
            .issue  (issue),
            .sel    (cur_instr[u*IDX_W +: IDX_W]),
            .word_q (ctrl_out[u*CTRL_W +: CTRL_W])
        );
    end

endmodule

// File: rtl/cfgseq_chk.sv
module cfgseq_chk #(
    parameter int AW  = 6,
    parameter int CBW = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           flag,
    input logic           busy,
    input logic           done,
    input logic [AW-1:0]  pc,
    input logic [CBW-1:0] ctrl_out,
    input logic [1:0]     op,
    input logic [AW-1:0]  target
);

    p_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done}));

    p_start_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && pc == '0));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op == 2'd0) |=> (pc == AW'($past(pc) + 1'b1)));

    p_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op == 2'd1) |=> (pc == $past(target)));

    p_cond_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op == 2'd2) |=>
        (pc == ($past(flag) ? $past(target) : AW'($past(pc) + 1'b1))));

    p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op == 2'd3) |=> (done && !busy && pc == $past(pc)));

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pc)));

    p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(ctrl_out));

endmodule

bind cfg_seq_top cfgseq_chk #(.AW(ADDR_W), .CBW(N_UNITS*CTRL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .flag     (flag),
    .busy     (busy),
    .done     (done),
    .pc       (pc),
    .ctrl_out (ctrl_out),
    .op       (cur_op),
    .target   (cur_target)
);

// File: tb/test_cfg_seq_top.sv
module test_cfg_seq_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        flag = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [19:0] wr_data = '0;
    logic [63:0] ctrl_out;
    logic [5:0]  pc;
    logic        busy;
    logic        done;

    int vecs = 0;
    int errs = 0;

    logic [19:0] bimem [64];
    logic [15:0] bcfg  [4][8];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_seq_top i_cfg_seq_top (
        .clk(clk), .rst_n(rst_n), .start(start), .flag(flag),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl_out(ctrl_out), .pc(pc), .busy(busy), .done(done)
    );

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL R6 watchdog: actual running expected halted");
        summary();
        $finish;
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] cval(int u, int e, int seed);
        return 16'(((u + 1) * 16'h1111) ^ (e * 16'h0203) ^ (seed * 16'h0F0F) ^ 16'h00A5);
    endfunction

    function automatic logic [19:0] mk(logic [1:0] op, logic [5:0] tgt,
                                       logic [2:0] i3, logic [2:0] i2,
                                       logic [2:0] i1, logic [2:0] i0);
        return {op, tgt, i3, i2, i1, i0};
    endfunction

    function automatic logic [63:0] exp_ctrl(logic [19:0] ins);
        logic [63:0] r;
        for (int u = 0; u < 4; u++) begin
            r[u*16 +: 16] = bcfg[u][ins[u*3 +: 3]];
        end
        return r;
    endfunction

    task automatic wr_instr(input int a, input logic [19:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_addr = 6'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        bimem[a] = d;
    endtask

    task automatic wr_cfg(input int u, input int e, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_addr = 6'(u * 8 + e); wr_data = {4'h0, d};
        @(negedge clk);
        wr_en = 1'b0;
        bcfg[u][e] = d;
    endtask

    // Runs the loaded program against the bench model; poke_step tries
    // a table write and a start pulse while running (both must be dropped).
    task automatic run_prog(input int max_steps, input logic [63:0] fpat,
                            input int poke_step, input string tag);
        int mpc = 0;
        bit halted = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", {tag, " busy after start"}, 64'(busy), 64'd1);
        chk("R2", {tag, " pc after start"}, 64'(pc), 64'd0);
        for (int s = 0; s < max_steps && !halted; s++) begin
            logic [19:0] ins;
            logic [1:0]  op;
            logic [5:0]  tgt;
            int          nxt;
            ins = bimem[mpc];
            op  = ins[19:18];
            tgt = ins[17:12];
            flag = fpat[s % 64];
            if (s == poke_step) begin
                start = 1'b1; wr_en = 1'b1; wr_sel = 1'b1;
                wr_addr = 6'd0; wr_data = 20'h0BEEF;
            end
            @(negedge clk);
            start = 1'b0; wr_en = 1'b0;
            chk("R7", {tag, " ctrl_out"}, ctrl_out, exp_ctrl(ins));
            case (op)
                2'd0: begin
                    nxt = (mpc + 1) % 64;
                    chk("R3", {tag, " step pc"}, 64'(pc), 64'(nxt));
                end
                2'd1: begin
                    nxt = int'(tgt);
                    chk("R4", {tag, " jump pc"}, 64'(pc), 64'(nxt));
                end
                2'd2: begin
                    nxt = fpat[s % 64] ? int'(tgt) : (mpc + 1) % 64;
                    chk("R5", {tag, " cond jump pc"}, 64'(pc), 64'(nxt));
                end
                default: begin
                    nxt = mpc;
                    chk("R6", {tag, " halt pc"}, 64'(pc), 64'(mpc));
                    chk("R6", {tag, " halt done"}, 64'(done), 64'd1);
                    chk("R6", {tag, " halt busy"}, 64'(busy), 64'd0);
                    halted = 1;
                end
            endcase
            mpc = nxt;
        end
        flag = 1'b0;
        chk("R6", {tag, " reached stop"}, 64'(halted), 64'd1);
    endtask

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy at reset", 64'(busy), 64'd0);
        chk("R1", "done at reset", 64'(done), 64'd0);
        chk("R1", "pc at reset", 64'(pc), 64'd0);
        chk("R1", "ctrl at reset", ctrl_out, 64'd0);

        // R9: load every table entry while idle
        for (int u = 0; u < 4; u++)
            for (int e = 0; e < 8; e++)
                wr_cfg(u, e, cval(u, e, 0));
        chk("R8", "ctrl idle after loads", ctrl_out, 64'd0);

        // Program A: sweep of every index per unit, stop at 63
        for (int i = 0; i < 64; i++) begin
            wr_instr(i, mk((i == 63) ? 2'd3 : 2'd0, 6'(i ^ 6'h2A),
                           3'((i + 9) % 8), 3'((i + 6) % 8),
                           3'((i + 3) % 8), 3'(i % 8)));
        end
        run_prog(80, 64'd0, -1, "A");

        held = ctrl_out;
        repeat (3) @(negedge clk);
        chk("R8", "ctrl held in done", ctrl_out, held);
        chk("R6", "done held", 64'(done), 64'd1);
        wr_cfg(2, 5, 16'h5A5A);
        chk("R8", "ctrl held after table write", ctrl_out, held);

        // Rerun with flag high (ignored by step) and a dropped write/start
        run_prog(80, '1, 5, "A2");

        // Program B: conditional both ways and wrap from 63 to 0
        wr_instr(0,  mk(2'd2, 6'd62, 3'd1, 3'd2, 3'd3, 3'd4));
        wr_instr(1,  mk(2'd3, 6'd0,  3'd7, 3'd7, 3'd7, 3'd7));
        wr_instr(62, mk(2'd0, 6'd5,  3'd0, 3'd5, 3'd0, 3'd5));
        wr_instr(63, mk(2'd0, 6'd9,  3'd6, 3'd1, 3'd6, 3'd1));
        run_prog(20, 64'h1, -1, "B");

        // Program C: unconditional jump and a flag-controlled loop
        wr_instr(0,  mk(2'd1, 6'd10, 3'd2, 3'd2, 3'd2, 3'd2));
        wr_instr(10, mk(2'd0, 6'd33, 3'd5, 3'd4, 3'd3, 3'd2));
        wr_instr(11, mk(2'd2, 6'd10, 3'd0, 3'd1, 3'd6, 3'd7));
        wr_instr(12, mk(2'd3, 6'd0,  3'd4, 3'd4, 3'd5, 3'd5));
        run_prog(20, 64'b10100, -1, "C");

        summary();
        $finish;
    end

endmodule